// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block routes up to 24 external interrupt lines to interrupt messages. Every line has its own redirection entry. The entry holds the vector to send and the delivery mode, which can be fixed, lowest priority or external. It also holds the destination addressing mode (physical or logical), the 8-bit destination, the input polarity and the trigger type (edge or level), plus a mask bit. Each line passes through a two-flop synchronizer and is XORed with its polarity bit. The result is an active-high request.

Software reaches the registers indirectly through two locations. It writes a register index to the select location. It then reads or writes the chosen 32-bit register through the data window, 16 bytes above the select location. The registers are an identification register, a read-only version/size register, an arbitration register, and two 32-bit words for each redirection entry.

Pending requests leave on a valid/ready message port, one message at a time. The lowest line index is served first. A level-triggered line sets its remote-IRR flag when its message is accepted. That flag blocks further messages from the line until an end-of-interrupt carrying the same vector is seen on the EOI input.

Top module: `intr_route_table`

## Requirements
- R1: The byte offset 0x00 on `bus_addr` is the select location and holds an 8-bit register index, which reads back in bits 7:0. Offset 0x10 is the data window onto the selected register.
- R2: Register 0x00 keeps a writable 4-bit ID in bits 27:24. Register 0x02 keeps a writable 4-bit arbitration ID in bits 27:24. All other bits of both read as zero.
- R3: Register 0x01 reads 0x00170011: version 0x11 in bits 7:0 and the highest entry index (NPINS-1) in bits 23:16. Writes to it have no effect.
- R4: Entry n has its low word at index 0x10+2n and its high word at 0x11+2n. The low word holds:
  - vector in bits 7:0
  - delivery mode in bits 10:8
  - destination mode in bit 11
  - delivery status in bit 12 (read-only)
  - polarity in bit 13
  - remote IRR in bit 14 (read-only)
  - trigger in bit 15 (1 = level)
  - mask in bit 16 (1 = disabled)
  - reserved bits, which read zero

  The high word holds the destination in bits 31:24, and its other bits read zero.
- R5: Writing the low word of an entry leaves its high word unchanged.
- R6: After reset every entry has its mask set and all its other fields clear, so the low word reads 0x00010000 and the high word reads 0.
- R7: An index that names no register reads as zero. A write to such an index changes no register.
- R8: An unmasked edge-triggered line sends exactly one message for each inactive-to-active transition. Holding the line active sends nothing more.
- R9: With polarity 1 the line is active low. With polarity 0 it is active high.
- R10: An unmasked level-triggered line sends a message while it is active and sets remote IRR when the message is accepted. It then sends nothing until an EOI whose vector matches the entry's vector clears remote IRR. An EOI with a different vector has no effect.
- R11: Delivery status reads 1 from the time a request is pending until its message handshake completes, and reads 0 otherwise.
- R12: When several lines are pending at once, the lowest line index is sent first.
- R13: A message carries the entry's vector, delivery mode, destination mode and destination. In physical mode only destination bits 3:0 are sent and the upper four bits are zero. The message holds steady while valid is high and ready is low.
- R14: A masked line sends nothing. A transition that happened while the line was masked is not sent later when it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset: 0x00 select, 0x10 data window |
| bus_wr | input | 1 | Write strobe for the addressed location |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed location (combinational) |
| irq_pin | input | NPINS | External interrupt lines (asynchronous) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_dstmode | output | 1 | Message destination mode (1 = logical) |
| msg_dest | output | 8 | Message destination |

## Verification
The bench builds the block with its default parameters: 24 lines and version 0x11. With these values the version register reads the fixed code 0x00170011. The last entry's high word sits at index 0x3F, so index 0x40 is the first unimplemented index past the table and can be probed. The directed scenarios cover the boundary entry 23 as well as low-index lines that compete for priority. They drive edge, level, active-low and masked lines and the matching and mismatching EOI cases, and they observe the message port and the read-back of delivery status and remote IRR.

// File: rtl/intr_route_table.sv
module intr_route_table #(
  parameter int          NPINS   = 24,
  parameter logic [7:0]  VERSION = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  irq_pin,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_dmode,
  output logic              msg_dstmode,
  output logic [7:0]        msg_dest
);

  localparam int         PW      = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [4:0] OFS_SEL = 5'h00;
  localparam logic [4:0] OFS_WIN = 5'h10;
  localparam logic [7:0] MAXIDX  = 8'(NPINS - 1);

  logic [7:0]       sel_idx;
  logic [3:0]       id_q, arb_q;
  logic [7:0]       vec   [NPINS];
  logic [2:0]       dmode [NPINS];
  logic [7:0]       dest  [NPINS];
  logic [NPINS-1:0] dstmode, pol, trig, mask, rirr, pend_e;
  logic [NPINS-1:0] s1, s2, act_d, act, req, dstat;
  logic [PW-1:0]    msg_pin, pick;
  logic             found;

  logic [7:0] win_off;
  logic [6:0] ent_ix;
  logic       ent_hit;
  logic [PW-1:0] ent;
  logic       win_wr;
  logic       accept;

  assign win_off = sel_idx - 8'h10;
  assign ent_ix  = win_off[7:1];
  assign ent_hit = (sel_idx >= 8'h10) && (ent_ix < 7'(NPINS));
  assign ent     = ent_ix[PW-1:0];
  assign win_wr  = bus_wr && (bus_addr == OFS_WIN);
  assign accept  = msg_valid && msg_ready;

  assign act = s2 ^ pol;
  assign req = ((trig & act & ~rirr) | (~trig & pend_e)) & ~mask;

  always_comb begin
    dstat = req;
    if (msg_valid) dstat[msg_pin] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx <= '0;
      id_q    <= '0;
      arb_q   <= '0;
    end else if (bus_wr && bus_addr == OFS_SEL) begin
      sel_idx <= bus_wdata[7:0];
    end else if (win_wr) begin
      if (sel_idx == 8'h00) id_q  <= bus_wdata[27:24];
      if (sel_idx == 8'h02) arb_q <= bus_wdata[27:24];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_SEL) begin
      bus_rdata = {24'h0, sel_idx};
    end else if (bus_addr == OFS_WIN) begin
      case (sel_idx)
        8'h00:   bus_rdata = {4'h0, id_q, 24'h0};
        8'h01:   bus_rdata = {8'h0, MAXIDX, 8'h0, VERSION};
        8'h02:   bus_rdata = {4'h0, arb_q, 24'h0};
        default: begin
          if (ent_hit) begin
            if (sel_idx[0])
              bus_rdata = {dest[ent], 24'h0};
            else
              bus_rdata = {15'h0, mask[ent], trig[ent], rirr[ent], pol[ent],
                           dstat[ent], dstmode[ent], dmode[ent], vec[ent]};
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= '0;
      s2    <= '0;
      act_d <= '0;
    end else begin
      s1    <= irq_pin;
      s2    <= s1;
      act_d <= act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) begin
        vec[i]     <= '0;
        dmode[i]   <= '0;
        dest[i]    <= '0;
        dstmode[i] <= 1'b0;
        pol[i]     <= 1'b0;
        trig[i]    <= 1'b0;
        mask[i]    <= 1'b1;
        rirr[i]    <= 1'b0;
        pend_e[i]  <= 1'b0;
      end
    end else begin
      for (int i = 0; i < NPINS; i++) begin
        if (win_wr && ent_hit && ent == PW'(i)) begin
          if (sel_idx[0]) begin
            dest[i] <= bus_wdata[31:24];
          end else begin
            vec[i]     <= bus_wdata[7:0];
            dmode[i]   <= bus_wdata[10:8];
            dstmode[i] <= bus_wdata[11];
            pol[i]     <= bus_wdata[13];
            trig[i]    <= bus_wdata[15];
            mask[i]    <= bus_wdata[16];
          end
        end
        if (act[i] && !act_d[i] && !mask[i] && !trig[i])
          pend_e[i] <= 1'b1;
        else if (accept && msg_pin == PW'(i))
          pend_e[i] <= 1'b0;
        if (accept && msg_pin == PW'(i) && trig[i])
          rirr[i] <= 1'b1;
        else if (eoi_valid && trig[i] && vec[i] == eoi_vector)
          rirr[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        pick  = PW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid   <= 1'b0;
      msg_pin     <= '0;
      msg_vector  <= '0;
      msg_dmode   <= '0;
      msg_dstmode <= 1'b0;
      msg_dest    <= '0;
    end else if (accept) begin
      msg_valid <= 1'b0;
    end else if (!msg_valid && found) begin
      msg_valid   <= 1'b1;
      msg_pin     <= pick;
      msg_vector  <= vec[pick];
      msg_dmode   <= dmode[pick];
      msg_dstmode <= dstmode[pick];
      msg_dest    <= dstmode[pick] ? dest[pick] : {4'h0, dest[pick][3:0]};
    end
  end

endmodule

// File: rtl/intr_route_table_chk.sv
module intr_route_table_chk #(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int        PW      = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [7:0]        sel_idx,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_vector,
  input logic              msg_dstmode,
  input logic [7:0]        msg_dest,
  input logic [PW-1:0]     msg_pin,
  input logic [NPINS-1:0]  dstat,
  input logic [NPINS-1:0]  rirr,
  input logic [NPINS-1:0]  trig
);

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest)); // R13

  AST_PHYS_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_dstmode |-> msg_dest[7:4] == 4'h0); // R13

  AST_VERSION_RD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 5'h10 && sel_idx == 8'h01 |-> bus_rdata == {8'h0, 8'(NPINS - 1), 8'h0, VERSION}); // R3

  AST_RIRR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && trig[msg_pin] |=> rirr[$past(msg_pin)]); // R10

  AST_DSTAT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> dstat[msg_pin]); // R11

endmodule

bind intr_route_table intr_route_table_chk #(.NPINS(NPINS), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .sel_idx(sel_idx), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_dstmode(msg_dstmode), .msg_dest(msg_dest),
  .msg_pin(msg_pin), .dstat(dstat), .rirr(rirr), .trig(trig));

// File: tb/intr_route_table_test.sv
module intr_route_table_test;
  localparam int NPINS = 24;

  logic clk = 0;
  logic rst_n = 0;
  logic [4:0] bus_addr = 0;
  logic bus_wr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [NPINS-1:0] irq_pin = 0;
  logic eoi_valid = 0;
  logic [7:0] eoi_vector = 0;
  logic msg_valid, msg_ready = 0, msg_dstmode;
  logic [7:0] msg_vector, msg_dest;
  logic [2:0] msg_dmode;

  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  intr_route_table uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pin(irq_pin),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dmode(msg_dmode),
    .msg_dstmode(msg_dstmode), .msg_dest(msg_dest));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rw(input logic [7:0] idx, input logic [31:0] d);
    bw(5'h00, {24'h0, idx});
    bw(5'h10, d);
  endtask

  task automatic rr(input logic [7:0] idx, output logic [31:0] d);
    bw(5'h00, {24'h0, idx});
    bus_addr = 5'h10;
    #1 d = bus_rdata;
  endtask

  task automatic wait_msg(input int n, output bit got);
    got = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (msg_valid) begin got = 1; break; end
    end
  endtask

  task automatic take_msg();
    @(negedge clk);
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R6 msg_valid idle", {31'h0, msg_valid}, 32'h0);
    rr(8'h00, d); check("R2 id reset", d, 32'h0);
    rr(8'h02, d); check("R2 arb reset", d, 32'h0);
    rr(8'h1A, d); check("R6 entry5 low", d, 32'h00010000);
    rr(8'h1B, d); check("R6 entry5 high", d, 32'h0);
    rr(8'h01, d); check("R3 version", d, 32'h00170011);
    bus_addr = 5'h00; #1;
    check("R1 select readback", bus_rdata, 32'h01);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    rw(8'h00, 32'hFFFFFFFF); rr(8'h00, d); check("R2 id field", d, 32'h0F000000);
    rw(8'h02, 32'hA5A5A5A5); rr(8'h02, d); check("R2 arb field", d, 32'h05000000);
    rw(8'h01, 32'h12345678); rr(8'h01, d); check("R3 read-only", d, 32'h00170011);
    rw(8'h03, 32'hFFFFFFFF); rr(8'h03, d); check("R7 unimpl 03", d, 32'h0);
    rr(8'h00, d); check("R7 id untouched", d, 32'h0F000000);
    rw(8'h40, 32'hFFFFFFFF); rr(8'h40, d); check("R7 unimpl 40", d, 32'h0);
    rw(8'h3F, 32'hABFFFFFF); rr(8'h3F, d); check("R4 entry23 high", d, 32'hAB000000);
    rw(8'h3E, 32'hFFFFFFFF); rr(8'h3E, d); check("R4 entry23 low", d, 32'h0001AFFF);
    rr(8'h3F, d); check("R5 high kept", d, 32'hAB000000);
    rw(8'h3E, 32'h00010000);
  endtask

  task automatic t_edge();
    logic [31:0] d; bit got;
    rw(8'h15, 32'h05000000);
    rw(8'h14, 32'h00000131);
    irq_pin[2] = 1;
    wait_msg(20, got); check("R8 edge msg", {31'h0, got}, 32'h1);
    check("R13 vector", {24'h0, msg_vector}, 32'h31);
    check("R13 dmode", {29'h0, msg_dmode}, 32'h1);
    check("R13 phys dest", {23'h0, msg_dstmode, msg_dest}, 32'h005);
    repeat (3) @(negedge clk);
    check("R13 hold", {23'h0, msg_valid, msg_vector}, 32'h131);
    rr(8'h14, d); check("R11 status busy", d, 32'h00001131);
    take_msg();
    rr(8'h14, d); check("R11 status done", d, 32'h00000131);
    wait_msg(20, got); check("R8 held line quiet", {31'h0, got}, 32'h0);
    rw(8'h15, 32'hF7000000);
    irq_pin[2] = 0; repeat (5) @(negedge clk); irq_pin[2] = 1;
    wait_msg(20, got); check("R8 second edge", {31'h0, got}, 32'h1);
    check("R13 phys dest trunc", {24'h0, msg_dest}, 32'h07);
    take_msg();
    rw(8'h14, 32'h00010131);
    irq_pin[2] = 0;
  endtask

  task automatic t_pol();
    bit got;
    irq_pin[4] = 1;
    repeat (4) @(negedge clk);
    rw(8'h19, 32'hC3000000);
    rw(8'h18, 32'h00002844);
    wait_msg(10, got); check("R9 high idle", {31'h0, got}, 32'h0);
    irq_pin[4] = 0;
    wait_msg(20, got); check("R9 low active", {31'h0, got}, 32'h1);
    check("R13 logical dest", {23'h0, msg_dstmode, msg_dest}, 32'h1C3);
    check("R9 vector", {24'h0, msg_vector}, 32'h44);
    take_msg();
    irq_pin[4] = 1;
    wait_msg(10, got); check("R9 release quiet", {31'h0, got}, 32'h0);
    rw(8'h18, 32'h00012844);
  endtask

  task automatic t_mask();
    bit got;
    rw(8'h1C, 32'h00010066);
    irq_pin[6] = 1;
    wait_msg(10, got); check("R14 masked", {31'h0, got}, 32'h0);
    rw(8'h1C, 32'h00000066);
    wait_msg(10, got); check("R14 no late edge", {31'h0, got}, 32'h0);
    irq_pin[6] = 0; repeat (5) @(negedge clk); irq_pin[6] = 1;
    wait_msg(20, got); check("R14 unmasked edge", {31'h0, got}, 32'h1);
    check("R14 vector", {24'h0, msg_vector}, 32'h66);
    take_msg();
    rw(8'h1C, 32'h00010066);
    irq_pin[6] = 0;
  endtask

  task automatic t_level();
    logic [31:0] d; bit got;
    rw(8'h20, 32'h00008088);
    irq_pin[8] = 1;
    wait_msg(20, got); check("R10 level msg", {31'h0, got}, 32'h1);
    check("R10 vector", {24'h0, msg_vector}, 32'h88);
    rr(8'h20, d); check("R11 level busy", d, 32'h00009088);
    take_msg();
    rr(8'h20, d); check("R10 remote irr set", d, 32'h0000C088);
    wait_msg(15, got); check("R10 blocked", {31'h0, got}, 32'h0);
    eoi(8'h89);
    wait_msg(15, got); check("R10 wrong eoi", {31'h0, got}, 32'h0);
    eoi(8'h88);
    wait_msg(15, got); check("R10 resend after eoi", {31'h0, got}, 32'h1);
    irq_pin[8] = 0;
    take_msg();
    rr(8'h20, d); check("R10 irr after second", d, 32'h0000C088);
    eoi(8'h88);
    rr(8'h20, d); check("R10 irr cleared", d, 32'h00008088);
    wait_msg(10, got); check("R10 inactive quiet", {31'h0, got}, 32'h0);
    rw(8'h20, 32'h00018088);
  endtask

  task automatic t_prio();
    bit got;
    rw(8'h16, 32'h00000013);
    rw(8'h1A, 32'h00000015);
    @(negedge clk);
    irq_pin[5] = 1; irq_pin[3] = 1;
    wait_msg(20, got); check("R12 first", {23'h0, got, msg_vector}, 32'h113);
    take_msg();
    wait_msg(20, got); check("R12 second", {23'h0, got, msg_vector}, 32'h115);
    take_msg();
    wait_msg(10, got); check("R12 drained", {31'h0, got}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_edge();
    t_pol();
    t_mask();
    t_level();
    t_prio();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule